// File: doc/BRIEF.md
# Dual Cascadable 8-Bit Compare Timer

This block holds two 8-bit timer channels behind a small byte-addressed register bus. Each channel has an up-counter, two compare registers (A and B), a control register, an output-select status register and a clock-select register. A channel can count a prescaled copy of the system clock or rising edges of its own external clock pin. It can also be stopped. When the counter equals a compare value on a count tick, the channel can clear the counter and raise a single-cycle interrupt pulse. A wrap past the maximum count raises a separate overflow pulse. Each pulse has its own enable bit.

The two channels can be joined in two ways. In the first, channel 0 selects chaining and both channels form one 16-bit counter. Channel 0 holds the high byte, channel 1 holds the low byte, and the compare registers pair up the same way. The 16-bit counter advances on channel 1's clock source and uses channel 0's control register and interrupt outputs. In the second, channel 0 runs on its own and channel 1 selects chaining. Channel 1 then counts the compare-A matches of channel 0. The output-select and converter-trigger fields are storage only.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset, both compare registers read 0xFF. The channel-1 status register reads 0x10. Every other register, including both counters, reads 0x00.
- R2: A byte access uses addr[3:1] to pick the register and addr[0] to pick the channel. The registers are: 0 control, 1 status, 2 compare A, 3 compare B, 4 counter, 5 clock control. Write data comes from wdata[7:0] and read data appears on rdata[7:0] with the upper byte zero. Control reads back only bits 7:3. Clock control reads back only bits 7 and 4:0. Status reads back bits 5:0, and on channel 1 bits 5:4 always read as 01. rdata is zero while the read strobe is low.
- R3: A halfword access (size nonzero) at an even address to compare A, compare B, counter or clock control carries channel 0 in bits 15:8 and channel 1 in bits 7:0, for both reads and writes.
- R4: These reads return 0xFFFF and the matching writes change nothing: a halfword access at an odd address, a halfword access to control or status, and any access to register index 6 or 7.
- R5: Clock control bits 4:3 select the source: 0 external pin, 1 prescaled internal, 2 none, 3 chain. For the internal source, bits 2:0 select stopped (0) or divide by 1, 2, 8, 32, 64, 1024 or 8192 (1 to 7). Over any window that is a whole number of prescale periods, the counter advances exactly window/divisor times.
- R6: Control bits 4:3 select clearing: 1 clears on compare A and 2 clears on compare B. On a tick where the counter equals the selected compare value, the counter becomes 0 instead of incrementing. Otherwise it increments and wraps.
- R7: A tick where the counter equals compare A gives a one-cycle pulse on the compare-A output one clock later, only if control bit 6 is set. Compare B does the same with bit 7. Overflow does the same with bit 5, and overflow means an increment from all ones to zero; a clear does not count as overflow.
- R8: With source 0, a channel counts each rising edge of its external clock input after a two-flop synchroniser.
- R9: When channel 0's source is chain, {counter0, counter1} is one 16-bit counter clocked by channel 1's source. It compares against {cmpA0, cmpA1} and {cmpB0, cmpB1}, uses channel 0's control and interrupt outputs, and overflows from 0xFFFF. Channel 1's interrupt outputs stay low.
- R10: When channel 1's source is chain and channel 0's is not, counter 1 increments once for each compare-A match tick of channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 4 | Byte address: register index in bits 3:1, channel in bit 0 |
| size_i | input | 2 | 0 byte access, nonzero halfword access |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Combinational read data |
| ext_clk_i | input | 2 | External count clocks, one per channel |
| cmpa_irq_o | output | 2 | Compare-A interrupt pulses per channel |
| cmpb_irq_o | output | 2 | Compare-B interrupt pulses per channel |
| ovf_irq_o | output | 2 | Overflow interrupt pulses per channel |

## Verification
A wrong clock-source or prescaler decode shows up as a wrong counter delta. The bench measures that delta over a window that is an exact multiple of the divisor, so the error is visible within one 64-cycle window. A wrong clear or enable decode changes how many interrupt pulses fall in a window that covers whole compare periods, and the count is off within a few hundred cycles. A broken carry between the chained bytes, or a broken match-driven chaining path, leaves a wrong 16-bit value after a handful of external edges. That value is read back directly through a halfword access.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned BW    = 8;
  localparam int unsigned NCH   = 2;
  localparam int unsigned PRE_W = 13;

  typedef enum logic [2:0] {
    R_CTL  = 3'd0,
    R_STAT = 3'd1,
    R_CMPA = 3'd2,
    R_CMPB = 3'd3,
    R_CNT  = 3'd4,
    R_CLK  = 3'd5
  } reg_e;

  typedef enum logic [1:0] {
    SRC_EXT   = 2'd0,
    SRC_INT   = 2'd1,
    SRC_OFF   = 2'd2,
    SRC_CHAIN = 2'd3
  } src_e;

  localparam logic [BW-1:0] CTL_MASK    = 8'hF8;
  localparam logic [BW-1:0] CLK_MASK    = 8'h9F;
  localparam logic [BW-1:0] STAT0_MASK  = 8'h3F;
  localparam logic [BW-1:0] STAT1_MASK  = 8'h0F;
  localparam logic [BW-1:0] STAT1_FIXED = 8'h10;

  // low prescaler bits that must all be one for a tick
  function automatic logic [PRE_W-1:0] div_mask(input logic [2:0] sel);
    case (sel)
      3'd2:    return PRE_W'(13'h0001);
      3'd3:    return PRE_W'(13'h0007);
      3'd4:    return PRE_W'(13'h001F);
      3'd5:    return PRE_W'(13'h003F);
      3'd6:    return PRE_W'(13'h03FF);
      3'd7:    return PRE_W'(13'h1FFF);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int unsigned N = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N-1:0][2:0]   sel_i,
  output logic [N-1:0]        tick_o
);
  logic [PRE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  for (genvar g = 0; g < N; g++) begin : g_tick
    logic [PRE_W-1:0] msk;
    assign msk       = div_mask(sel_i[g]);
    assign tick_o[g] = (sel_i[g] != 3'd0) && ((cnt_q & msk) == msk);
  end
endmodule

// File: rtl/tmr_ext_sync.sv
module tmr_ext_sync #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] ext_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= ext_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;
endmodule

// File: rtl/tmr_count_step.sv
module tmr_count_step #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] cmpa_i,
  input  logic [W-1:0] cmpb_i,
  input  logic [1:0]   clr_sel_i,
  output logic [W-1:0] nxt_o,
  output logic         match_a_o,
  output logic         match_b_o,
  output logic         wrap_o
);
  logic clr;

  assign match_a_o = (cnt_i == cmpa_i);
  assign match_b_o = (cnt_i == cmpb_i);
  assign clr       = (clr_sel_i == 2'd1 && match_a_o) || (clr_sel_i == 2'd2 && match_b_o);
  assign nxt_o     = clr ? '0 : cnt_i + 1'b1;
  assign wrap_o    = !clr && (&cnt_i);
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
  import tmr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       addr_i,
  input  logic [1:0]       size_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [2*BW-1:0]  wdata_i,
  output logic [2*BW-1:0]  rdata_o,
  input  logic [NCH-1:0]   ext_clk_i,
  output logic [NCH-1:0]   cmpa_irq_o,
  output logic [NCH-1:0]   cmpb_irq_o,
  output logic [NCH-1:0]   ovf_irq_o
);
  localparam int unsigned CW = 2 * BW;

  logic [BW-1:0] ctl_q  [NCH];
  logic [BW-1:0] stat_q [NCH];
  logic [BW-1:0] cmpa_q [NCH];
  logic [BW-1:0] cmpb_q [NCH];
  logic [BW-1:0] cnt_q  [NCH];
  logic [BW-1:0] clk_q  [NCH];

  // bus decode
  logic [2:0] ridx;
  logic       half, half_ok, ridx_ok, byte_we, half_we;
  logic [NCH-1:0] ch_we, cnt_we;
  logic [BW-1:0]  wbyte [NCH];
  logic [BW-1:0]  rb    [NCH];

  assign ridx    = addr_i[3:1];
  assign half    = (size_i != 2'd0);
  assign ridx_ok = (ridx <= R_CLK);
  assign half_ok = !addr_i[0] && (ridx >= R_CMPA) && ridx_ok;
  assign byte_we = wr_i && !half && ridx_ok;
  assign half_we = wr_i && half && half_ok;
  assign ch_we[0] = (byte_we && !addr_i[0]) || half_we;
  assign ch_we[1] = (byte_we &&  addr_i[0]) || half_we;
  assign wbyte[0] = half ? wdata_i[CW-1:BW] : wdata_i[BW-1:0];
  assign wbyte[1] = wdata_i[BW-1:0];

  for (genvar c = 0; c < NCH; c++) begin : g_rd
    assign cnt_we[c] = ch_we[c] && (ridx == R_CNT);
    always_comb begin
      case (ridx)
        R_CTL:   rb[c] = ctl_q[c];
        R_STAT:  rb[c] = (c == 1) ? (stat_q[c] | STAT1_FIXED) : stat_q[c];
        R_CMPA:  rb[c] = cmpa_q[c];
        R_CMPB:  rb[c] = cmpb_q[c];
        R_CNT:   rb[c] = cnt_q[c];
        R_CLK:   rb[c] = clk_q[c];
        default: rb[c] = '0;
      endcase
    end
  end

  always_comb begin
    if (!rd_i)        rdata_o = '0;
    else if (half)    rdata_o = half_ok ? {rb[0], rb[1]} : '1;
    else if (ridx_ok) rdata_o = {{BW{1'b0}}, rb[addr_i[0]]};
    else              rdata_o = '1;
  end

  // configuration registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < NCH; c++) begin
        ctl_q[c]  <= '0;
        stat_q[c] <= '0;
        cmpa_q[c] <= '1;
        cmpb_q[c] <= '1;
        clk_q[c]  <= '0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (ch_we[c]) begin
          case (ridx)
            R_CTL:   ctl_q[c]  <= wbyte[c] & CTL_MASK;
            R_STAT:  stat_q[c] <= wbyte[c] & ((c == 0) ? STAT0_MASK : STAT1_MASK);
            R_CMPA:  cmpa_q[c] <= wbyte[c];
            R_CMPB:  cmpb_q[c] <= wbyte[c];
            R_CLK:   clk_q[c]  <= wbyte[c] & CLK_MASK;
            default: ;
          endcase
        end
      end
    end
  end

  // clock sources
  logic [NCH-1:0][2:0] pre_sel;
  logic [NCH-1:0]      pre_tick, ext_rise, base_tick;
  src_e                src [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_src
    assign pre_sel[c]   = clk_q[c][2:0];
    assign src[c]       = src_e'(clk_q[c][4:3]);
    assign base_tick[c] = (src[c] == SRC_INT) ? pre_tick[c] :
                          (src[c] == SRC_EXT) ? ext_rise[c] : 1'b0;
  end

  tmr_prescaler #(.N(NCH)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (pre_sel),
    .tick_o (pre_tick)
  );

  tmr_ext_sync #(.N(NCH)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ext_i  (ext_clk_i),
    .rise_o (ext_rise)
  );

  // count steps: two byte channels and one chained word
  logic [BW-1:0]  nxt8 [NCH];
  logic [NCH-1:0] ma8, mb8, wr8;
  logic [CW-1:0]  nxt16;
  logic           ma16, mb16, wr16;

  for (genvar c = 0; c < NCH; c++) begin : g_step
    tmr_count_step #(.W(BW)) u_step (
      .cnt_i     (cnt_q[c]),
      .cmpa_i    (cmpa_q[c]),
      .cmpb_i    (cmpb_q[c]),
      .clr_sel_i (ctl_q[c][4:3]),
      .nxt_o     (nxt8[c]),
      .match_a_o (ma8[c]),
      .match_b_o (mb8[c]),
      .wrap_o    (wr8[c])
    );
  end

  tmr_count_step #(.W(CW)) u_step16 (
    .cnt_i     ({cnt_q[0], cnt_q[1]}),
    .cmpa_i    ({cmpa_q[0], cmpa_q[1]}),
    .cmpb_i    ({cmpb_q[0], cmpb_q[1]}),
    .clr_sel_i (ctl_q[0][4:3]),
    .nxt_o     (nxt16),
    .match_a_o (ma16),
    .match_b_o (mb16),
    .wrap_o    (wr16)
  );

  logic cascade, tick0, tick1, tick16;
  assign cascade = (src[0] == SRC_CHAIN);
  assign tick0   = !cascade && base_tick[0];
  assign tick1   = !cascade && ((src[1] == SRC_CHAIN) ? (tick0 && ma8[0]) : base_tick[1]);
  assign tick16  = cascade && base_tick[1];

  // bus write to the counter wins over a tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q[0] <= '0;
      cnt_q[1] <= '0;
    end else begin
      if (cnt_we[0])   cnt_q[0] <= wbyte[0];
      else if (tick16) cnt_q[0] <= nxt16[CW-1:BW];
      else if (tick0)  cnt_q[0] <= nxt8[0];
      if (cnt_we[1])   cnt_q[1] <= wbyte[1];
      else if (tick16) cnt_q[1] <= nxt16[BW-1:0];
      else if (tick1)  cnt_q[1] <= nxt8[1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmpa_irq_o <= '0;
      cmpb_irq_o <= '0;
      ovf_irq_o  <= '0;
    end else begin
      cmpa_irq_o[0] <= ((tick16 && ma16) || (tick0 && ma8[0])) && ctl_q[0][6];
      cmpb_irq_o[0] <= ((tick16 && mb16) || (tick0 && mb8[0])) && ctl_q[0][7];
      ovf_irq_o[0]  <= ((tick16 && wr16) || (tick0 && wr8[0])) && ctl_q[0][5];
      cmpa_irq_o[1] <= tick1 && ma8[1] && ctl_q[1][6];
      cmpb_irq_o[1] <= tick1 && mb8[1] && ctl_q[1][7];
      ovf_irq_o[1]  <= tick1 && wr8[1] && ctl_q[1][5];
    end
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rd_i,
  input logic [1:0]  size_i,
  input logic [3:0]  addr_i,
  input logic [15:0] rdata_o,
  input logic        cascade_i,
  input logic        tick0_i,
  input logic        match_a0_i,
  input logic [1:0]  cnt_we_i,
  input logic [7:0]  ctl0_i,
  input logic [7:0]  clk0_i,
  input logic [7:0]  clk1_i,
  input logic [7:0]  cnt0_i,
  input logic [7:0]  cnt1_i,
  input logic [1:0]  cmpa_irq_i,
  input logic [1:0]  cmpb_irq_i,
  input logic [1:0]  ovf_irq_i
);
  a_r4_bad_half_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && size_i != 2'd0 && (addr_i[0] || addr_i[3:1] < 3'd2)) |-> rdata_o == 16'hFFFF);

  a_r5_stopped_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk0_i[4:3] == 2'd1 && clk0_i[2:0] == 3'd0 && !cnt_we_i[0]) |=> $stable(cnt0_i));

  a_r6_clear_on_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick0_i && match_a0_i && ctl0_i[4:3] == 2'd1 && !cnt_we_i[0]) |=> cnt0_i == 8'h00);

  a_r7_ovf_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_irq_i[0] |-> $past(ctl0_i[5]));

  a_r9_ch1_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cascade_i |=> (cmpa_irq_i[1] == 1'b0 && cmpb_irq_i[1] == 1'b0 && ovf_irq_i[1] == 1'b0));

  a_r10_chain_only_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cascade_i && clk1_i[4:3] == 2'd3 && !cnt_we_i[1] && !(tick0_i && match_a0_i))
      |=> $stable(cnt1_i));
endmodule

bind dual_cmp_timer tmr_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_i       (rd_i),
  .size_i     (size_i),
  .addr_i     (addr_i),
  .rdata_o    (rdata_o),
  .cascade_i  (cascade),
  .tick0_i    (tick0),
  .match_a0_i (ma8[0]),
  .cnt_we_i   (cnt_we),
  .ctl0_i     (ctl_q[0]),
  .clk0_i     (clk_q[0]),
  .clk1_i     (clk_q[1]),
  .cnt0_i     (cnt_q[0]),
  .cnt1_i     (cnt_q[1]),
  .cmpa_irq_i (cmpa_irq_o),
  .cmpb_irq_i (cmpb_irq_o),
  .ovf_irq_i  (ovf_irq_o)
);

// File: tb/dual_cmp_timer_tb_top.sv
module dual_cmp_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic [1:0]  size = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [1:0]  ext = '0;
  logic [1:0]  cmpa_irq, cmpb_irq, ovf_irq;

  always #5 clk = ~clk;

  dual_cmp_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .size_i(size),
    .wr_i(wr), .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata),
    .ext_clk_i(ext), .cmpa_irq_o(cmpa_irq), .cmpb_irq_o(cmpb_irq), .ovf_irq_o(ovf_irq)
  );

  int n_chk = 0, n_fail = 0;
  int mon_a[2] = '{0, 0};
  int mon_b[2] = '{0, 0};
  int mon_o[2] = '{0, 0};
  logic [7:0] sh[4][2];

  always @(negedge clk) begin
    for (int c = 0; c < 2; c++) begin
      mon_a[c] += int'(cmpa_irq[c]);
      mon_b[c] += int'(cmpb_irq[c]);
      mon_o[c] += int'(ovf_irq[c]);
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic hw, input logic [15:0] d);
    @(negedge clk);
    addr = a; size = hw ? 2'd1 : 2'd0; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, input logic hw, output logic [15:0] d);
    @(negedge clk);
    addr = a; size = hw ? 2'd1 : 2'd0; rd = 1'b1;
    #1 d = rdata;
    rd = 1'b0;
  endtask

  task automatic ext_pulse(input int c);
    @(negedge clk) ext[c] = 1'b1;
    repeat (3) @(negedge clk);
    ext[c] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_byte(input int r, input int c);
    case (r)
      0:       return sh[r][c] & 8'hF8;
      1:       return (c == 1) ? ((sh[r][c] & 8'h0F) | 8'h10) : (sh[r][c] & 8'h3F);
      default: return sh[r][c];
    endcase
  endfunction

  // counter delta over a window of n cycles, byte channel c
  task automatic delta(input int c, input int n, output logic [7:0] dv);
    logic [15:0] v1, v2;
    bus_rd(4'(8 + c), 1'b0, v1);
    repeat (n - 1) @(negedge clk);
    bus_rd(4'(8 + c), 1'b0, v2);
    dv = v2[7:0] - v1[7:0];
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  dv;
    int s0, s1, s2, s3, s4, s5;
    int unsigned seed;
    seed = $urandom(32'd24680);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    for (int r = 0; r < 6; r++) begin
      for (int c = 0; c < 2; c++) begin
        bus_rd(4'(2 * r + c), 1'b0, v);
        check("R1 reset", v, (r == 2 || r == 3) ? 16'h00FF : (r == 1 && c == 1) ? 16'h0010 : 16'h0000);
      end
    end
    @(negedge clk); addr = 4'd4; size = 2'd0; rd = 1'b0;
    #1 check("R2 rd low gives zero", rdata, 16'h0000);
    bus_rd(4'd12, 1'b0, v); check("R4 unmapped read", v, 16'hFFFF);

    // R2/R3/R4 constrained random register traffic (counters stay idle)
    for (int c = 0; c < 2; c++) begin
      sh[0][c] = 8'h00; sh[1][c] = 8'h00; sh[2][c] = 8'hFF; sh[3][c] = 8'hFF;
    end
    for (int i = 0; i < 150; i++) begin
      int r, c, rr, rc;
      logic hw, rhw;
      logic [15:0] d;
      r = int'($urandom_range(0, 3)); c = int'($urandom_range(0, 1));
      hw = ($urandom_range(0, 3) == 0); d = 16'($urandom);
      bus_wr(4'(2 * r + c), hw, d);
      if (hw) begin
        if (c == 0 && r >= 2) begin sh[r][0] = d[15:8]; sh[r][1] = d[7:0]; end
      end else sh[r][c] = d[7:0];
      rr = int'($urandom_range(0, 3)); rc = int'($urandom_range(0, 1));
      rhw = ($urandom_range(0, 2) == 0);
      bus_rd(4'(2 * rr + rc), rhw, v);
      if (rhw) check((rc == 0 && rr >= 2) ? "R3 half read" : "R4 illegal half",
                     v, (rc == 0 && rr >= 2) ? {exp_byte(rr, 0), exp_byte(rr, 1)} : 16'hFFFF);
      else check("R2 byte read", v, {8'h00, exp_byte(rr, rc)});
    end

    // R2 clock-control read mask, R3 halfword pairing, R4 ignored writes
    bus_wr(4'd11, 1'b0, 16'h00E7);
    bus_rd(4'd11, 1'b0, v); check("R2 clk mask", v, 16'h0087);
    bus_wr(4'd11, 1'b0, 16'h0000);
    bus_wr(4'd4, 1'b1, 16'h1234);
    bus_rd(4'd4, 1'b0, v); check("R3 half hi to ch0", v, 16'h0012);
    bus_rd(4'd5, 1'b0, v); check("R3 half lo to ch1", v, 16'h0034);
    bus_wr(4'd5, 1'b1, 16'hABCD);
    bus_rd(4'd4, 1'b1, v); check("R4 odd half write ignored", v, 16'h1234);
    bus_wr(4'd14, 1'b0, 16'h00AA);
    bus_rd(4'd4, 1'b1, v); check("R4 unmapped write ignored", v, 16'h1234);

    // R5 prescaler
    bus_wr(4'd10, 1'b0, 16'h0000);
    bus_wr(4'd0, 1'b0, 16'h0000);
    bus_wr(4'd8, 1'b0, 16'h0000);
    bus_wr(4'd10, 1'b0, 16'h000B); delta(0, 64, dv); check("R5 div8", {8'h0, dv}, 16'd8);
    bus_wr(4'd10, 1'b0, 16'h000A); delta(0, 64, dv); check("R5 div2", {8'h0, dv}, 16'd32);
    bus_wr(4'd10, 1'b0, 16'h0009); delta(0, 64, dv); check("R5 div1", {8'h0, dv}, 16'd64);
    bus_wr(4'd10, 1'b0, 16'h000C); delta(0, 64, dv); check("R5 div32", {8'h0, dv}, 16'd2);
    bus_wr(4'd10, 1'b0, 16'h0008); delta(0, 64, dv); check("R5 stopped", {8'h0, dv}, 16'd0);
    bus_wr(4'd10, 1'b0, 16'h0013); delta(0, 64, dv); check("R5 no source", {8'h0, dv}, 16'd0);

    // R6/R7 clear on A, pulses gated by enable
    bus_wr(4'd10, 1'b0, 16'h0000);
    bus_wr(4'd0, 1'b0, 16'h0048);
    bus_wr(4'd4, 1'b0, 16'h0005);
    bus_wr(4'd8, 1'b0, 16'h0000);
    bus_wr(4'd10, 1'b0, 16'h0009);
    repeat (20) @(negedge clk);
    #1 s0 = mon_a[0];
    repeat (60) @(negedge clk);
    #1 check("R6 clear on A period 6", 16'(mon_a[0] - s0), 16'd10);

    // R6/R7 clear on B, compare A disabled
    bus_wr(4'd10, 1'b0, 16'h0000);
    bus_wr(4'd0, 1'b0, 16'h0090);
    bus_wr(4'd6, 1'b0, 16'h0009);
    bus_wr(4'd8, 1'b0, 16'h0000);
    bus_wr(4'd10, 1'b0, 16'h0009);
    repeat (20) @(negedge clk);
    #1 begin s0 = mon_a[0]; s1 = mon_b[0]; end
    repeat (100) @(negedge clk);
    #1 begin
      check("R6 clear on B period 10", 16'(mon_b[0] - s1), 16'd10);
      check("R7 compare A gated off", 16'(mon_a[0] - s0), 16'd0);
    end

    // R7 overflow with and without enable
    bus_wr(4'd0, 1'b0, 16'h0020);
    repeat (5) @(negedge clk);
    #1 s0 = mon_o[0];
    repeat (512) @(negedge clk);
    #1 check("R7 overflow count", 16'(mon_o[0] - s0), 16'd2);
    bus_wr(4'd0, 1'b0, 16'h0000);
    #1 s0 = mon_o[0];
    repeat (512) @(negedge clk);
    #1 check("R7 overflow gated off", 16'(mon_o[0] - s0), 16'd0);
    bus_wr(4'd10, 1'b0, 16'h0000);

    // R8 external clock on channel 1
    bus_wr(4'd1, 1'b0, 16'h0000);
    bus_wr(4'd11, 1'b0, 16'h0000);
    bus_wr(4'd9, 1'b0, 16'h0000);
    repeat (5) ext_pulse(1);
    repeat (5) @(negedge clk);
    bus_rd(4'd9, 1'b0, v); check("R8 external edges", v, 16'h0005);

    // R9 chained 16-bit counter
    bus_wr(4'd10, 1'b0, 16'h0018);
    bus_wr(4'd8, 1'b1, 16'h00FD);
    bus_wr(4'd4, 1'b1, 16'h0102);
    bus_wr(4'd0, 1'b0, 16'h0048);
    repeat (5) ext_pulse(1);
    repeat (5) @(negedge clk);
    bus_rd(4'd8, 1'b1, v); check("R9 carry into high byte", v, 16'h0102);
    #1 begin s0 = mon_a[0]; s1 = mon_a[1]; s2 = mon_b[1]; s3 = mon_o[1]; end
    ext_pulse(1);
    repeat (5) @(negedge clk);
    bus_rd(4'd8, 1'b1, v); check("R9 16-bit clear on A", v, 16'h0000);
    check("R9 ch0 compare pulse", 16'(mon_a[0] - s0), 16'd1);
    check("R9 ch1 outputs quiet", 16'((mon_a[1] - s1) + (mon_b[1] - s2) + (mon_o[1] - s3)), 16'd0);
    bus_wr(4'd0, 1'b0, 16'h0020);
    bus_wr(4'd8, 1'b1, 16'hFFFF);
    #1 begin s4 = mon_o[0]; s5 = mon_o[1]; end
    ext_pulse(1);
    repeat (5) @(negedge clk);
    bus_rd(4'd8, 1'b1, v); check("R9 16-bit wrap", v, 16'h0000);
    check("R9 16-bit overflow pulse", 16'(mon_o[0] - s4), 16'd1);
    check("R9 ch1 overflow quiet", 16'(mon_o[1] - s5), 16'd0);

    // R10 channel 1 counts channel 0 compare-A matches
    bus_wr(4'd10, 1'b0, 16'h0000);
    bus_wr(4'd0, 1'b0, 16'h0008);
    bus_wr(4'd4, 1'b0, 16'h0003);
    bus_wr(4'd8, 1'b0, 16'h0000);
    bus_wr(4'd11, 1'b0, 16'h0018);
    bus_wr(4'd9, 1'b0, 16'h0000);
    repeat (8) ext_pulse(0);
    repeat (5) @(negedge clk);
    bus_rd(4'd9, 1'b0, v); check("R10 chained match count", v, 16'h0002);
    bus_rd(4'd8, 1'b0, v); check("R10 ch0 cleared", v, 16'h0000);

    summary();
  end
endmodule